// File: doc/BRIEF.md
# Logic Self-Test Wrapper with Pseudo-Random Stimulus and Signature Compaction

The block wraps a small combinational circuit that sits outside it. In normal mode the system inputs reach the circuit unchanged. In test mode an input multiplexer cuts the system inputs off. A linear feedback shift register then drives the circuit inputs. Every circuit response is folded into a multiple-input signature register.

A test controller runs a fixed sequence. It seeds the generator and clears the signature. It applies a parameterised number of patterns, one per clock. It then compares the final signature with a golden value given as a parameter, and reports done and pass.

The generator polynomial is given as a tap mask. A parameter picks the feedback style: external, with the XOR network on the feedback path, or internal, with XOR gates between stages. A second parameter swaps the polynomial for its reciprocal.

Top module: `lbist_wrapper`

## Requirements
- R1: With `test_mode` low, `cut_in` equals `sys_in` in every cycle, and `start` has no effect: `done` and `pass` stay 0.
- R2: With `test_mode` high, `cut_in` carries the generator state, and `sys_in` has no effect on it. After reset and while idle, that state is the seed.
- R3: The generator state is never all-zero. A zero seed parameter is replaced by the value 1.
- R4: The generator is updated one step per RUN cycle. In external style it shifts left, and bit 0 takes the XOR of `q[W-1-i]` over every set tap bit `i`. In internal style it shifts left with a 0 entering bit 0, and the tap mask is XORed in when the old bit `W-1` was 1. The default tap mask 4'b0011 (x^4+x+1) and its reciprocal (x^4+x^3+1, mask 4'b1001) both visit 15 distinct nonzero states and return to the seed after 15 steps.
- R5: The signature register is cleared on the SEED cycle. On each RUN cycle it becomes its value shifted left, XORed with the signature tap mask when the old top bit was 1, XORed with `cut_resp`. The default signature tap mask is 4'b0011.
- R6: After `start` is sampled high in IDLE (or DONE) with `test_mode` high, the controller spends one SEED cycle, then PATTERNS RUN cycles, then one COMPARE cycle, and then enters DONE. `done` is high only in DONE.
- R7: `pass` is high only while `done` is high, and only when the final signature equals GOLDEN.
- R8: In DONE the signature holds its value whatever `cut_resp` does. A new `start` restarts the full sequence.
- R9: Dropping `test_mode` in any state returns the controller to IDLE on the next edge, clearing `done` and `pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 selects self-test, 0 selects normal pass-through |
| start | input | 1 | Begins a self-test run when sampled high in IDLE or DONE |
| sys_in | input | GEN_W | Normal-mode stimulus for the circuit |
| cut_resp | input | RSP_W | Responses returned by the circuit under test |
| cut_in | output | GEN_W | Stimulus driven into the circuit under test |
| done | output | 1 | High while the controller is in DONE |
| pass | output | 1 | High in DONE when the signature matched GOLDEN |
| signature | output | RSP_W | Current signature register contents |

## Verification
Two situations can fall in the same cycle. First, the withdrawal of `test_mode` can land on a RUN cycle that would otherwise step the generator and capture a response. The bench drops the mode five patterns into a run, then checks that `done` and `pass` fall at once, that `cut_in` follows `sys_in` again, and that a later run still reloads the seed and matches the golden value. Second, a restart `start` can arrive in the DONE state, where the signature is meant to hold. The bench toggles the circuit responses while in DONE, checks that the signature does not move, and then restarts straight from DONE with an injected stuck-at fault. It checks that the new verdict follows its own model signature and not the previous one.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int MAXW = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED,
        ST_RUN,
        ST_CMP,
        ST_DONE
    } lbist_state_e;

    typedef struct packed {
        logic load;   // seed generator, clear signature
        logic step;   // advance generator, capture response
        logic judge;  // latch comparison verdict
    } lbist_ctl_t;

    // Low tap mask of x^n * P(1/x) given the low tap mask of P(x) (x^n implied).
    function automatic logic [MAXW-1:0] mirror_taps(input logic [MAXW-1:0] taps, input int n);
        logic [MAXW-1:0] r;
        r    = '0;
        r[0] = 1'b1;
        for (int i = 1; i < MAXW; i++) begin
            if (i < n) r[i] = taps[n-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/lbist_tpg.sv
module lbist_tpg
    import lbist_pkg::*;
#(
    parameter int             W        = 4,
    parameter logic [W-1:0]   TAPS     = 4'b0011,
    parameter bit             INTERNAL = 1'b0,
    parameter bit             RECIP    = 1'b0,
    parameter logic [W-1:0]   SEED     = 4'b0001
) (
    input  logic         clk,
    input  logic         rst,
    input  lbist_ctl_t   ctl,
    output logic [W-1:0] q
);

    localparam logic [MAXW-1:0] MIR   = mirror_taps({{(MAXW-W){1'b0}}, TAPS}, W);
    localparam logic [W-1:0]    EFF   = RECIP ? MIR[W-1:0] : TAPS;
    localparam logic [W-1:0]    START = (SEED == '0) ? {{(W-1){1'b0}}, 1'b1} : SEED;

    logic [W-1:0] nxt;

    generate
        if (INTERNAL) begin : g_internal
            always_comb begin
                nxt = {q[W-2:0], 1'b0} ^ (q[W-1] ? EFF : '0);
            end
        end else begin : g_external
            logic fb;
            always_comb begin
                fb = 1'b0;
                for (int i = 0; i < W; i++) begin
                    fb = fb ^ (EFF[i] & q[W-1-i]);
                end
                nxt = {q[W-2:0], fb};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || ctl.load) q <= START;
        else if (ctl.step)   q <= nxt;
    end

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
    import lbist_pkg::*;
#(
    parameter int           W    = 4,
    parameter logic [W-1:0] TAPS = 4'b0011
) (
    input  logic         clk,
    input  logic         rst,
    input  lbist_ctl_t   ctl,
    input  logic [W-1:0] resp,
    output logic [W-1:0] sig
);

    logic [W-1:0] nxt;

    always_comb begin
        nxt = {sig[W-2:0], 1'b0} ^ (sig[W-1] ? TAPS : '0) ^ resp;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.load) sig <= '0;
        else if (ctl.step)   sig <= nxt;
    end

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int PATTERNS = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         test_mode,
    input  logic         start,
    input  logic         sig_match,
    output lbist_state_e state,
    output lbist_ctl_t   ctl,
    output logic         done,
    output logic         pass
);

    localparam int            CW   = $clog2(PATTERNS + 1);
    localparam logic [CW-1:0] LAST = CW'(PATTERNS - 1);

    logic [CW-1:0] cnt;
    logic          verdict;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            verdict <= 1'b0;
        end else if (!test_mode) begin
            state   <= ST_IDLE;
            verdict <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= ST_SEED;
                ST_SEED: begin
                    cnt     <= '0;
                    verdict <= 1'b0;
                    state   <= ST_RUN;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_CMP;
                end
                ST_CMP: begin
                    verdict <= sig_match;
                    state   <= ST_DONE;
                end
                ST_DONE: if (start) state <= ST_SEED;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load  = test_mode && (state == ST_SEED);
        ctl.step  = test_mode && (state == ST_RUN);
        ctl.judge = test_mode && (state == ST_CMP);
        done      = (state == ST_DONE);
        pass      = done && verdict;
    end

endmodule

// File: rtl/lbist_wrapper.sv
module lbist_wrapper
    import lbist_pkg::*;
#(
    parameter int               GEN_W       = 4,
    parameter int               RSP_W       = 4,
    parameter int               PATTERNS    = 15,
    parameter logic [GEN_W-1:0] GEN_TAPS    = 4'b0011,
    parameter logic [RSP_W-1:0] SIG_TAPS    = 4'b0011,
    parameter bit               FB_INTERNAL = 1'b0,
    parameter bit               USE_RECIP   = 1'b0,
    parameter logic [GEN_W-1:0] SEED        = 4'b0001,
    parameter logic [RSP_W-1:0] GOLDEN      = 4'b0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_mode,
    input  logic             start,
    input  logic [GEN_W-1:0] sys_in,
    input  logic [RSP_W-1:0] cut_resp,
    output logic [GEN_W-1:0] cut_in,
    output logic             done,
    output logic             pass,
    output logic [RSP_W-1:0] signature
);

    lbist_state_e     state;
    lbist_ctl_t       ctl;
    logic [GEN_W-1:0] gen_q;
    logic             sig_match;

    assign sig_match = (signature == GOLDEN);

    lbist_ctrl #(.PATTERNS(PATTERNS)) u_ctrl (
        .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
        .sig_match(sig_match), .state(state), .ctl(ctl),
        .done(done), .pass(pass)
    );

    lbist_tpg #(
        .W(GEN_W), .TAPS(GEN_TAPS), .INTERNAL(FB_INTERNAL),
        .RECIP(USE_RECIP), .SEED(SEED)
    ) u_tpg (
        .clk(clk), .rst(rst), .ctl(ctl), .q(gen_q)
    );

    lbist_misr #(.W(RSP_W), .TAPS(SIG_TAPS)) u_misr (
        .clk(clk), .rst(rst), .ctl(ctl), .resp(cut_resp), .sig(signature)
    );

    // Input isolation: generator owns the circuit inputs in test mode.
    assign cut_in = test_mode ? gen_q : sys_in;

endmodule

// File: rtl/lbist_checker.sv
module lbist_checker
    import lbist_pkg::*;
#(
    parameter int GEN_W = 4,
    parameter int RSP_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             test_mode,
    input lbist_state_e     st,
    input logic [GEN_W-1:0] cut_in,
    input logic             done,
    input logic             pass,
    input logic [RSP_W-1:0] signature
);

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        test_mode |-> (cut_in != '0)); // R3

    AST_GEN_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && test_mode) |=> (!test_mode || cut_in != $past(cut_in))); // R4

    AST_SEED_CLEARS_SIG: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SEED && test_mode) |=> (signature == '0)); // R5

    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        pass |-> done); // R7

    AST_DONE_HOLDS_SIG: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(signature)); // R8

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !test_mode |=> (!done && !pass)); // R9

endmodule

bind lbist_wrapper lbist_checker #(.GEN_W(GEN_W), .RSP_W(RSP_W)) u_chk (
    .clk(clk), .rst(rst), .test_mode(test_mode), .st(state),
    .cut_in(cut_in), .done(done), .pass(pass), .signature(signature)
);

// File: tb/lbist_wrapper_test.sv
`timescale 1ns/1ps
module lbist_wrapper_test;

    localparam int         NPAT = 15;
    localparam logic [3:0] SEEDV = 4'h1;

    // Circuit under test model, with optional stuck-at-1 on response bit 0.
    function automatic logic [3:0] cut_f(input logic [3:0] x, input bit fault);
        logic [3:0] r;
        r = {x[3] ^ x[1], x[2] & ~x[0], x[1] | x[2], x[0] ^ x[3] ^ x[2]};
        if (fault) r[0] = 1'b1;
        return r;
    endfunction

    function automatic logic [4:0] gen_poly(input bit recip);
        return recip ? 5'b11001 : 5'b10011;
    endfunction

    function automatic logic [3:0] gen_step(input logic [3:0] s, input bit internal, input bit recip);
        logic [4:0] p, t;
        logic       fb;
        p = gen_poly(recip);
        if (internal) begin
            t = {s, 1'b0};
            if (t[4]) t = t ^ p;
            return t[3:0];
        end
        fb = (p[0] & s[3]) ^ (p[1] & s[2]) ^ (p[2] & s[1]) ^ (p[3] & s[0]);
        return {s[2:0], fb};
    endfunction

    function automatic logic [3:0] sig_step(input logic [3:0] s, input logic [3:0] r);
        logic [4:0] t;
        t = {s, 1'b0};
        if (t[4]) t = t ^ 5'b10011;
        return t[3:0] ^ r;
    endfunction

    function automatic logic [3:0] ref_sig(input bit internal, input bit recip, input bit fault);
        logic [3:0] g, s;
        g = SEEDV;
        s = 4'h0;
        for (int k = 0; k < NPAT; k++) begin
            s = sig_step(s, cut_f(g, fault));
            g = gen_step(g, internal, recip);
        end
        return s;
    endfunction

    localparam logic [3:0] GOLD_A = ref_sig(1'b0, 1'b0, 1'b0);
    localparam logic [3:0] GOLD_B = ref_sig(1'b1, 1'b1, 1'b0);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       test_mode = 1'b0;
    logic       start = 1'b0;
    logic [3:0] sys_in = 4'h0;
    bit         fault_a = 1'b0;

    logic [3:0] cut_in_a, cut_in_b, resp_a, resp_b, sig_a, sig_b;
    logic       done_a, done_b, pass_a, pass_b;

    assign resp_a = cut_f(cut_in_a, fault_a);
    assign resp_b = cut_f(cut_in_b, 1'b0);

    always #2.5 clk = ~clk;

    lbist_wrapper #(.PATTERNS(NPAT), .SEED(SEEDV), .GOLDEN(GOLD_A)) uut (
        .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
        .sys_in(sys_in), .cut_resp(resp_a), .cut_in(cut_in_a),
        .done(done_a), .pass(pass_a), .signature(sig_a)
    );

    lbist_wrapper #(.PATTERNS(NPAT), .SEED(SEEDV), .FB_INTERNAL(1'b1),
                    .USE_RECIP(1'b1), .GOLDEN(GOLD_B)) uut_alt (
        .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
        .sys_in(sys_in), .cut_resp(resp_b), .cut_in(cut_in_b),
        .done(done_b), .pass(pass_b), .signature(sig_b)
    );

    int n_checks = 0;
    int n_err    = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One complete run; starts and ends at a negative edge.
    task automatic run_test(input bit fault);
        logic [3:0] ga, gb, sa, sb;
        logic [15:0] seen_a, seen_b;
        fault_a = fault;
        ga = SEEDV; gb = SEEDV; sa = 4'h0; sb = 4'h0;
        seen_a = '0; seen_b = '0;
        start = 1'b1;
        @(negedge clk);          // SEED cycle
        start = 1'b0;
        chk(!done_a, "R6", "done low in SEED", done_a, 0);
        for (int k = 0; k < NPAT; k++) begin
            @(negedge clk);      // RUN cycle k
            chk(cut_in_a == ga, "R4", "external generator state", cut_in_a, ga);
            chk(cut_in_b == gb, "R4", "internal reciprocal state", cut_in_b, gb);
            chk(cut_in_a != 0 && cut_in_b != 0, "R3", "generator nonzero", cut_in_a, 1);
            chk(sig_a == sa, "R5", "signature during run", sig_a, sa);
            chk(sig_b == sb, "R5", "alt signature during run", sig_b, sb);
            chk(!done_a && !pass_a, "R6", "done low in RUN", done_a, 0);
            seen_a[cut_in_a] = 1'b1;
            seen_b[cut_in_b] = 1'b1;
            sa = sig_step(sa, cut_f(ga, fault));
            sb = sig_step(sb, cut_f(gb, 1'b0));
            ga = gen_step(ga, 1'b0, 1'b0);
            gb = gen_step(gb, 1'b1, 1'b1);
        end
        @(negedge clk);          // COMPARE cycle
        chk($countones(seen_a) == NPAT, "R4", "distinct external states", $countones(seen_a), NPAT);
        chk($countones(seen_b) == NPAT, "R4", "distinct reciprocal states", $countones(seen_b), NPAT);
        chk(cut_in_a == SEEDV && cut_in_b == SEEDV, "R4", "period returns to seed", cut_in_a, SEEDV);
        chk(!done_a, "R6", "done low in COMPARE", done_a, 0);
        @(negedge clk);          // DONE
        chk(done_a && done_b, "R6", "done after seed+run+compare", done_a, 1);
        chk(sig_a == sa, "R5", "final signature", sig_a, sa);
        chk(sig_b == sb, "R5", "alt final signature", sig_b, sb);
        chk(pass_a == (sa == GOLD_A), "R7", "pass verdict", pass_a, (sa == GOLD_A));
        chk(pass_b == 1'b1, "R7", "alt pass verdict", pass_b, 1);
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done_a && !pass_a, "R6", "reset done/pass", done_a, 0);
        chk(sig_a == 4'h0, "R5", "reset signature", sig_a, 0);
        rst = 1'b0;

        // R1: pass-through sweep, start ignored
        start = 1'b1;
        for (int v = 0; v < 16; v++) begin
            sys_in = 4'(v);
            @(negedge clk);
            chk(cut_in_a == 4'(v) && cut_in_b == 4'(v), "R1", "normal pass-through", cut_in_a, v);
        end
        start = 1'b0;
        chk(!done_a && !pass_a, "R1", "start ignored in normal mode", done_a, 0);

        // R2: isolation sweep in test mode while idle
        test_mode = 1'b1;
        for (int v = 0; v < 16; v++) begin
            sys_in = 4'(v);
            @(negedge clk);
            chk(cut_in_a == SEEDV && cut_in_b == SEEDV, "R2", "system input blocked", cut_in_a, SEEDV);
        end

        run_test(1'b0);

        // R8: signature holds in DONE while responses change
        begin
            logic [3:0] held;
            held = sig_a;
            for (int k = 0; k < 4; k++) begin
                fault_a = ~fault_a;
                @(negedge clk);
                chk(sig_a == held && done_a, "R8", "signature held in DONE", sig_a, held);
            end
        end

        // R8: restart from DONE with injected stuck-at fault
        run_test(1'b1);
        chk(pass_a == (ref_sig(1'b0, 1'b0, 1'b1) == GOLD_A), "R7", "faulty verdict", pass_a, 0);
        run_test(1'b0);

        // R9: abort in the middle of RUN
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        test_mode = 1'b0;
        sys_in = 4'hA;
        @(negedge clk);
        chk(!done_a && !pass_a, "R9", "abort clears done/pass", done_a, 0);
        chk(cut_in_a == 4'hA, "R9", "pass-through after abort", cut_in_a, 4'hA);
        repeat (NPAT + 4) @(negedge clk);
        chk(!done_a, "R9", "run not resumed", done_a, 0);
        test_mode = 1'b1;
        @(negedge clk);
        run_test(1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule